// File: doc/BRIEF.md
# Receiver-Enable Training Sequencer

This block steps a memory controller through hardware-assisted receiver-enable training. After a `start` pulse it brackets the run with an environment setup step and a restore step. It visits every controller in turn, and within each controller every chip select from the lowest to the highest. A chip select with no valid test address is passed over.

For each populated chip select, the sequencer works in a fixed order. On an even chip select it first picks the DIMM and asks the seed block to prepare start values. It then turns on training in the phy and asks the read generator for a back-to-back read stream. It holds training on for a fixed count of cycles, turns training off, and asks the combiner block to compute the final delay. When a controller's chip selects are done, it loads the maximum read latency if a maximum delay was found, then resets the write pointer.

A second pass is run only when the current speed is above the boot speed; otherwise the run reports success at once. Every handshake to a sub-block has a cycle limit. If the limit is missed, the fatal flag is set and the run jumps to the restore step.

Top module: `rxen_train_seq`

## Requirements
- R1: During reset and after it, with no `start`, `busy`, `done`, `ok`, `fatal` and every request and strobe output are low, and `ctl_sel`, `cs_sel` and `dimm_sel` are zero.
- R2: If `start` arrives with `second_pass`=1 and `cur_speed` not greater than `boot_speed`, the next cycle shows `done`=1 and `ok`=1. No setup step, restore step or request appears.
- R3: `env_begin` is high for exactly the first cycle after an accepted `start`. `env_end` is high for exactly the cycle before `done`.
- R4: Controllers are visited in ascending order, and chip selects 0 to CS_PER_CTL-1 in ascending order within each one. Each chip select spends one check cycle on `cs_sel`. The valid bit for controller c, chip select s, is `cs_valid[c*CS_PER_CTL+s]`. A chip select whose bit is 0 raises no request. At most one of `seed_start`, `rd_req` and `comb_start` is high at a time.
- R5: For a valid even chip select, `dimm_sel` takes the value cs>>1 and `seed_start` is held high until `seed_done`, before training starts. A valid odd chip select raises no `seed_start` and leaves `dimm_sel` unchanged.
- R6: `phy_train_en` and `rd_req` rise together, and `rd_req` stays high until `rd_ack`. `phy_train_en` then stays high for exactly WAIT_CYCLES more cycles and falls as `comb_start` rises. `comb_start` is held until `comb_done`.
- R7: After the last chip select of a controller, one cycle shows `maxlat_load` equal to `maxdly_found`. The next cycle shows `wrptr_reset`=1 with `wrptr_code`=6. `wrptr_code` is 0 in every other cycle.
- R8: If a request is still unanswered after TIMEOUT cycles, the run drops it, raises `fatal`, goes to the `env_end` cycle, and ends with `done`=1 and `ok`=0.
- R9: An answer that arrives in the last permitted cycle (the TIMEOUT-th cycle of the request) counts as success. The sequence goes on and `fatal` stays low.
- R10: `done` is a single-cycle pulse with `ok` = not `fatal`. `fatal` holds its value until the next accepted `start` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only while idle |
| second_pass | input | 1 | 1 selects the second training pass |
| cur_speed | input | SPD_W | Current memory speed |
| boot_speed | input | SPD_W | Start-up memory speed |
| cs_valid | input | NUM_CTL*CS_PER_CTL | Chip select has a valid test address |
| maxdly_found | input | 1 | A maximum delay was found for the controller |
| seed_done | input | 1 | Seed block finished |
| rd_ack | input | 1 | Read generator accepted the burst |
| comb_done | input | 1 | Final-delay combiner finished |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (one cycle) |
| ok | output | 1 | Run finished without fatal error |
| fatal | output | 1 | A handshake timed out |
| env_begin | output | 1 | Environment setup strobe |
| env_end | output | 1 | Environment restore strobe |
| ctl_sel | output | CTL_W | Current controller |
| cs_sel | output | CS_W | Current chip select |
| dimm_sel | output | DIMM_W | Selected DIMM |
| seed_start | output | 1 | Seed preparation request |
| phy_train_en | output | 1 | Phy receiver-enable training enable |
| rd_req | output | 1 | Back-to-back read request |
| comb_start | output | 1 | Final-delay computation request |
| maxlat_load | output | 1 | Load maximum read latency |
| wrptr_reset | output | 1 | Write pointer reset strobe |
| wrptr_code | output | 4 | Write pointer reset value |

## Verification
A sub-block answer and the timeout limit can land in the same cycle. The bench provokes this by setting a responder latency exactly equal to TIMEOUT, so `seed_done`, `rd_ack` or `comb_done` rises in the last cycle the sequencer still waits. The reference model expects the answer to win: the next state follows as normal and `fatal` stays low. Other cases use a latency one cycle longer, or no answer at all, where the abort to `env_end` with `fatal` high is expected.

// File: rtl/rxen_pkg.sv
package rxen_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_BEGIN,
    S_CHECK,
    S_SEED,
    S_TRON,
    S_HOLD,
    S_COMB,
    S_CTLEND,
    S_WRPTR,
    S_END,
    S_DONE
  } rx_state_e;

  // second pass is pointless unless the clock went up since boot
  function automatic logic pass_skipped(input logic second, input logic [31:0] cur,
                                        input logic [31:0] boot);
    return second && !(cur > boot);
  endfunction

  // a handshake is answered or abandoned; the answer has priority
  function automatic logic hs_gives_up(input logic answered, input logic at_limit);
    return at_limit && !answered;
  endfunction

endpackage

// File: rtl/rxen_tick_timer.sv
module rxen_tick_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             count <= '0;
    else if (clr)           count <= '0;
    else if (count != '1)   count <= count + 1'b1;
  end

endmodule

// File: rtl/rxen_cursor.sv
module rxen_cursor #(
  parameter int NUM_CTL    = 2,
  parameter int CS_PER_CTL = 8,
  parameter int CTL_W      = 1,
  parameter int CS_W       = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          restart,
  input  logic                          cs_step,
  input  logic                          ctl_step,
  input  logic [NUM_CTL*CS_PER_CTL-1:0] cs_valid,
  output logic [CTL_W-1:0]              ctl,
  output logic [CS_W-1:0]               cs,
  output logic                          cs_last,
  output logic                          ctl_last,
  output logic                          cs_ok
);

  localparam int IDX_W = $clog2(NUM_CTL*CS_PER_CTL + 1);

  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
      cs  <= '0;
    end else if (restart) begin
      ctl <= '0;
      cs  <= '0;
    end else if (ctl_step) begin
      ctl <= ctl + 1'b1;
      cs  <= '0;
    end else if (cs_step) begin
      cs  <= cs + 1'b1;
    end
  end

  assign idx      = IDX_W'(ctl) * IDX_W'(CS_PER_CTL) + IDX_W'(cs);
  assign cs_ok    = cs_valid[idx];
  assign cs_last  = (cs == CS_W'(CS_PER_CTL - 1));
  assign ctl_last = (ctl == CTL_W'(NUM_CTL - 1));

endmodule

// File: rtl/rxen_train_seq.sv
module rxen_train_seq
  import rxen_pkg::*;
#(
  parameter int NUM_CTL       = 2,
  parameter int CS_PER_CTL    = 8,
  parameter int SPD_W         = 16,
  parameter int WAIT_CYCLES   = 200,
  parameter int TIMEOUT       = 1024,
  parameter int WRPTR_RST_VAL = 6,
  localparam int CTL_W  = (NUM_CTL > 1) ? $clog2(NUM_CTL) : 1,
  localparam int CS_W   = (CS_PER_CTL > 1) ? $clog2(CS_PER_CTL) : 1,
  localparam int DIMM_W = (CS_W > 1) ? CS_W - 1 : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          second_pass,
  input  logic [SPD_W-1:0]              cur_speed,
  input  logic [SPD_W-1:0]              boot_speed,
  input  logic [NUM_CTL*CS_PER_CTL-1:0] cs_valid,
  input  logic                          maxdly_found,
  input  logic                          seed_done,
  input  logic                          rd_ack,
  input  logic                          comb_done,
  output logic                          busy,
  output logic                          done,
  output logic                          ok,
  output logic                          fatal,
  output logic                          env_begin,
  output logic                          env_end,
  output logic [CTL_W-1:0]              ctl_sel,
  output logic [CS_W-1:0]               cs_sel,
  output logic [DIMM_W-1:0]             dimm_sel,
  output logic                          seed_start,
  output logic                          phy_train_en,
  output logic                          rd_req,
  output logic                          comb_start,
  output logic                          maxlat_load,
  output logic                          wrptr_reset,
  output logic [3:0]                    wrptr_code
);

  localparam int SPAN  = (WAIT_CYCLES > TIMEOUT) ? WAIT_CYCLES : TIMEOUT;
  localparam int TMR_W = $clog2(SPAN + 1);

  rx_state_e state, state_nxt;

  logic [TMR_W-1:0] tmr;
  logic             cs_last, ctl_last, cs_ok;
  logic             cs_step, ctl_step;

  // named internal events
  logic ev_accept;     // start taken while idle
  logic ev_answer;     // current handshake answered
  logic ev_limit;      // handshake window used up
  logic ev_timeout;    // abandoned handshake
  logic ev_hold_over;  // training hold interval finished
  logic ev_seed_pick;  // even chip select latches the DIMM

  assign ev_accept    = (state == S_IDLE) && start;
  assign ev_answer    = ((state == S_SEED) && seed_done) ||
                        ((state == S_TRON) && rd_ack) ||
                        ((state == S_COMB) && comb_done);
  assign ev_limit     = (tmr == TMR_W'(TIMEOUT - 1)) &&
                        (state == S_SEED || state == S_TRON || state == S_COMB);
  assign ev_timeout   = hs_gives_up(ev_answer, ev_limit);
  assign ev_hold_over = (state == S_HOLD) && (tmr == TMR_W'(WAIT_CYCLES - 1));
  assign ev_seed_pick = (state == S_CHECK) && cs_ok && !cs_sel[0];

  always_comb begin
    state_nxt = state;
    cs_step   = 1'b0;
    ctl_step  = 1'b0;
    case (state)
      S_IDLE:   if (start)
                  state_nxt = pass_skipped(second_pass, 32'(cur_speed), 32'(boot_speed))
                              ? S_DONE : S_BEGIN;
      S_BEGIN:  state_nxt = S_CHECK;
      S_CHECK:  if (cs_ok)          state_nxt = cs_sel[0] ? S_TRON : S_SEED;
                else if (cs_last)   state_nxt = S_CTLEND;
                else                cs_step   = 1'b1;
      S_SEED:   if (ev_answer)      state_nxt = S_TRON;
                else if (ev_timeout) state_nxt = S_END;
      S_TRON:   if (ev_answer)      state_nxt = S_HOLD;
                else if (ev_timeout) state_nxt = S_END;
      S_HOLD:   if (ev_hold_over)   state_nxt = S_COMB;
      S_COMB:   if (ev_answer) begin
                  state_nxt = cs_last ? S_CTLEND : S_CHECK;
                  cs_step   = !cs_last;
                end else if (ev_timeout) state_nxt = S_END;
      S_CTLEND: state_nxt = S_WRPTR;
      S_WRPTR:  begin
                  state_nxt = ctl_last ? S_END : S_CHECK;
                  ctl_step  = !ctl_last;
                end
      S_END:    state_nxt = S_DONE;
      S_DONE:   state_nxt = S_IDLE;
      default:  state_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      fatal    <= 1'b0;
      dimm_sel <= '0;
    end else begin
      state <= state_nxt;
      if (ev_accept)         fatal <= 1'b0;
      else if (ev_timeout)   fatal <= 1'b1;
      if (ev_accept)         dimm_sel <= '0;
      else if (ev_seed_pick) dimm_sel <= DIMM_W'(cs_sel >> 1);
    end
  end

  rxen_tick_timer #(.CNT_W(TMR_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_nxt != state),
    .count (tmr)
  );

  rxen_cursor #(
    .NUM_CTL    (NUM_CTL),
    .CS_PER_CTL (CS_PER_CTL),
    .CTL_W      (CTL_W),
    .CS_W       (CS_W)
  ) u_cursor (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (ev_accept),
    .cs_step  (cs_step),
    .ctl_step (ctl_step),
    .cs_valid (cs_valid),
    .ctl      (ctl_sel),
    .cs       (cs_sel),
    .cs_last  (cs_last),
    .ctl_last (ctl_last),
    .cs_ok    (cs_ok)
  );

  assign busy         = (state != S_IDLE);
  assign done         = (state == S_DONE);
  assign ok           = done && !fatal;
  assign env_begin    = (state == S_BEGIN);
  assign env_end      = (state == S_END);
  assign seed_start   = (state == S_SEED);
  assign rd_req       = (state == S_TRON);
  assign phy_train_en = (state == S_TRON) || (state == S_HOLD);
  assign comb_start   = (state == S_COMB);
  assign maxlat_load  = (state == S_CTLEND) && maxdly_found;
  assign wrptr_reset  = (state == S_WRPTR);
  assign wrptr_code   = wrptr_reset ? 4'(WRPTR_RST_VAL) : 4'd0;

  // ---------------- assertions ----------------
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seed_start, rd_req, comb_start})); // R4
  AST_SEED_ON_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    seed_start |-> (!cs_sel[0] && dimm_sel == DIMM_W'(cs_sel >> 1))); // R5
  AST_READ_WHILE_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> phy_train_en); // R6
  AST_COMB_AFTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    comb_start |-> !phy_train_en); // R6
  AST_WRPTR_AFTER_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    wrptr_reset |-> $past(state == S_CTLEND)); // R7
  AST_TIMEOUT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> (env_end && fatal)); // R8
  AST_ANSWER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_answer |=> $stable(fatal)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

endmodule

// File: tb/rxen_train_seq_test.sv
module rxen_train_seq_test;

  localparam int TO   = 16;
  localparam int HOLD = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, second_pass = 1'b0;
  logic [15:0] cur_speed = '0, boot_speed = '0;
  logic [15:0] cs_valid = '0;
  logic        maxdly_found = 1'b0;
  logic        seed_done = 1'b0, rd_ack = 1'b0, comb_done = 1'b0;

  logic busy, done, ok, fatal, env_begin, env_end;
  logic [0:0] ctl_sel;
  logic [2:0] cs_sel;
  logic [1:0] dimm_sel;
  logic seed_start, phy_train_en, rd_req, comb_start, maxlat_load, wrptr_reset;
  logic [3:0] wrptr_code;

  rxen_train_seq #(.TIMEOUT(TO), .WAIT_CYCLES(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .second_pass(second_pass),
    .cur_speed(cur_speed), .boot_speed(boot_speed), .cs_valid(cs_valid),
    .maxdly_found(maxdly_found), .seed_done(seed_done), .rd_ack(rd_ack),
    .comb_done(comb_done), .busy(busy), .done(done), .ok(ok), .fatal(fatal),
    .env_begin(env_begin), .env_end(env_end), .ctl_sel(ctl_sel), .cs_sel(cs_sel),
    .dimm_sel(dimm_sel), .seed_start(seed_start), .phy_train_en(phy_train_en),
    .rd_req(rd_req), .comb_start(comb_start), .maxlat_load(maxlat_load),
    .wrptr_reset(wrptr_reset), .wrptr_code(wrptr_code)
  );

  always #4 clk = ~clk;  // 125 MHz

  typedef struct packed {
    logic busy, done, ok, fatal, eb, ee, seed, tren, rd, comb, mlat, wrp;
    logic [3:0] wcode;
    logic [1:0] dimm;
    logic [2:0] cs;
    logic       ctl;
  } vec_t;

  vec_t  q[$];
  int    n_vec = 0, n_bad = 0;
  string case_tag = "R1";
  int    lat_seed = 1, lat_rd = 1, lat_comb = 1;
  int    cnt_seed = 0, cnt_rd = 0, cnt_comb = 0;
  bit    m_fatal = 0;
  logic [1:0] m_dimm = 0;
  logic [2:0] m_cs = 0;
  logic       m_ctl = 0;

  function automatic vec_t base(bit is_busy);
    vec_t v = '0;
    v.busy = is_busy; v.fatal = m_fatal;
    v.dimm = m_dimm; v.cs = m_cs; v.ctl = m_ctl;
    return v;
  endfunction

  // one handshake window: returns 1 when it is abandoned
  function automatic bit model_hs(int kind, int lat);
    bit answered = (lat >= 1 && lat <= TO);
    int n = answered ? lat : TO;
    for (int i = 0; i < n; i++) begin
      vec_t v = base(1);
      if (kind == 0) v.seed = 1;
      if (kind == 1) begin v.rd = 1; v.tren = 1; end
      if (kind == 2) v.comb = 1;
      q.push_back(v);
    end
    if (!answered) m_fatal = 1;
    return !answered;
  endfunction

  task automatic build_model(bit p2, int spd, int sspd, logic [15:0] mask, bit mf);
    vec_t v;
    bit   abort = 0;
    m_fatal = 0; m_dimm = 0; m_cs = 0; m_ctl = 0;
    if (p2 && !(spd > sspd)) begin
      v = base(1); v.done = 1; v.ok = 1; q.push_back(v);
      return;
    end
    v = base(1); v.eb = 1; q.push_back(v);
    for (int c = 0; c < 2 && !abort; c++) begin
      m_ctl = 1'(c);
      for (int s = 0; s < 8 && !abort; s++) begin
        m_cs = 3'(s);
        q.push_back(base(1));
        if (mask[c*8+s]) begin
          if (s % 2 == 0) begin
            m_dimm = 2'(s >> 1);
            abort = model_hs(0, lat_seed);
          end
          if (!abort) abort = model_hs(1, lat_rd);
          if (!abort) begin
            for (int h = 0; h < HOLD; h++) begin
              v = base(1); v.tren = 1; q.push_back(v);
            end
            abort = model_hs(2, lat_comb);
          end
        end
      end
      if (!abort) begin
        v = base(1); v.mlat = mf; q.push_back(v);
        v = base(1); v.wrp = 1; v.wcode = 4'd6; q.push_back(v);
      end
    end
    v = base(1); v.ee = 1; q.push_back(v);
    v = base(1); v.done = 1; v.ok = !m_fatal; q.push_back(v);
  endtask

  task automatic cmp(string req, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s (case %s) t=%0t got=%h exp=%h", req, case_tag, $time, got, exp);
    end
  endtask

  always @(posedge clk) begin
    vec_t e;
    #2;
    e = (q.size() != 0) ? q.pop_front() : base(0);
    cmp(rst_n ? "R10" : "R1", 32'({busy, done, ok, fatal}), 32'({e.busy, e.done, e.ok, e.fatal}));
    cmp(rst_n ? "R3" : "R1", 32'({env_begin, env_end}), 32'({e.eb, e.ee}));
    cmp(rst_n ? "R4" : "R1", 32'({ctl_sel, cs_sel}), 32'({e.ctl, e.cs}));
    cmp(rst_n ? "R5" : "R1", 32'({seed_start, dimm_sel}), 32'({e.seed, e.dimm}));
    cmp(rst_n ? "R6" : "R1", 32'({phy_train_en, rd_req, comb_start}), 32'({e.tren, e.rd, e.comb}));
    cmp(rst_n ? "R7" : "R1", 32'({maxlat_load, wrptr_reset, wrptr_code}), 32'({e.mlat, e.wrp, e.wcode}));
  end

  // responders: answer in the lat-th cycle of a held request, 0 = never
  always @(negedge clk) begin
    if (seed_start) begin cnt_seed++; seed_done = (lat_seed != 0 && cnt_seed == lat_seed); end
    else begin cnt_seed = 0; seed_done = 0; end
    if (rd_req) begin cnt_rd++; rd_ack = (lat_rd != 0 && cnt_rd == lat_rd); end
    else begin cnt_rd = 0; rd_ack = 0; end
    if (comb_start) begin cnt_comb++; comb_done = (lat_comb != 0 && cnt_comb == lat_comb); end
    else begin cnt_comb = 0; comb_done = 0; end
  end

  task automatic run(string tag, bit p2, int spd, int sspd, logic [15:0] mask, bit mf,
                     int ls, int lr, int lc);
    @(negedge clk);
    case_tag = tag;
    lat_seed = ls; lat_rd = lr; lat_comb = lc;
    second_pass = p2; cur_speed = 16'(spd); boot_speed = 16'(sspd);
    cs_valid = mask; maxdly_found = mf;
    build_model(p2, spd, sspd, mask, mf);
    start = 1;
    @(negedge clk);
    start = 0;
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);           // R1: reset values compared each cycle
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R4 R5 R6 R7: mixed even/odd chip selects over both controllers
    run("R5", 0, 400, 400, 16'b0100_1000_0000_0111, 1, 3, 2, 4);
    // R2: second pass at unchanged speed is skipped
    run("R2", 1, 400, 400, 16'hFFFF, 1, 1, 1, 1);
    // R2 complement: second pass at higher speed runs; odd cs only, no max delay
    run("R7", 1, 533, 400, 16'b0000_0000_0010_0000, 0, 2, 1, 1);
    // R8: read generator never answers
    run("R8", 0, 400, 400, 16'b0000_0000_0000_0001, 1, 1, 0, 1);
    // R9: every answer lands in the last permitted cycle; R10 clears fatal
    run("R9", 0, 400, 400, 16'b0000_0100_0000_0000, 1, TO, TO, TO);
    // R8: combiner one cycle too late
    run("R8", 0, 400, 400, 16'b0000_0000_0001_0000, 0, 1, 1, TO + 1);
    // R8: seed block too late
    run("R8", 0, 400, 400, 16'b0000_0001_0000_0000, 0, TO + 1, 1, 1);
    // R4: nothing populated
    run("R4", 0, 400, 400, 16'h0000, 1, 1, 1, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (case %s) got=hung exp=finished", case_tag);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule